// File: doc/BRIEF.md
# HDLC Serial Transmit Framer

This block turns a stream of frame bytes into a serial HDLC line bitstream, one line bit per clock. Bytes arrive on a valid/ready interface, and a marker on the final byte closes the frame. The block wraps each frame in 0x7E flags and inserts a zero after any five consecutive ones in the frame body. It appends a frame check sequence, either 16 or 32 bits wide, chosen from a two-bit mode input. When nothing is queued, the line carries an unbroken run of flags.

A four-bit spacing input sets the minimum number of extra idle flags between the closing flag of one frame and the opening flag of the next. Software may rewrite this field while traffic is flowing. The block captures the field when a closing flag begins, so a rewrite takes effect at the next inter-frame gap. The CRC mode is captured when the first byte of a frame is accepted. If the source runs dry in the middle of a frame, the frame is closed as though the last byte taken had been marked final.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With no frame offered, `tx_bit` carries back-to-back flags 0x7E and no frame body appears.
- R2: Each frame starts after an opening flag. Each data byte goes out least significant bit first, in the order the bytes were accepted.
- R3: A zero is inserted after every run of five ones in data and CRC bits. Flags are never stuffed, so the line never carries more than six ones in a row.
- R4: The check sequence starts at all ones. It is updated over the data bits in line order, using polynomial 0x1021 for CRC-16 or 0x04C11DB7 for CRC-32. It is sent complemented, most significant bit first, and is followed by a closing flag.
- R5: Mode code 2'b10 selects CRC-32 and every other code selects CRC-16. The mode is sampled when a frame's first byte is accepted, and a later change does not alter that frame.
- R6: With spacing value N, exactly N+2 flags separate the last check bit of one frame from the first data bit of a waiting next frame: the closing flag, N extra flags and the opening flag.
- R7: With N=0 and back-to-back frames, the closing flag is followed directly by the next opening flag, giving exactly two flags.
- R8: The spacing value present when a closing flag begins governs the gap that follows. A change made during that gap first affects the next gap.
- R9: After reset, a frame offered at once is preceded by exactly N+1 flags, with N read live until that first frame starts.
- R10: `in_ready` is high only on the last bit cycle of a flag or a non-final data byte. It is low in reset, during CRC bits and during stuffed bits, so accepted bytes are at least 8 cycles apart.
- R11: A byte accepted with `in_last` high is the final data byte of its frame, and the CRC follows it at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_min_flags | input | 4 | Minimum extra flags between frames, changeable at any time |
| cfg_crc_mode | input | 2 | CRC select: 2'b10 selects CRC-32, any other code selects CRC-16 |
| in_valid | input | 1 | A frame byte is offered |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Offered byte ends the frame |
| in_ready | output | 1 | Byte is taken on this clock edge when valid is high |
| tx_bit | output | 1 | Serial line bit, registered |

## Verification
On every cycle, the checker confirms three things: the line never shows a run of seven ones, accepted bytes are never closer than eight cycles, and ready never stays high for two cycles in a row. It also checks that a CRC restart happens only together with a byte acceptance, and never in the same cycle as a CRC update.

Other behaviour can only be shown by the bench's scenarios. These are the exact bit order of data and CRC, the flag counts in each gap under different spacing values, spacing and mode changes made at chosen moments, and the flag count after reset. A bench receiver removes stuffed bits from the line, finds the frames and compares them with frames computed independently.

// File: rtl/hdlc_tx_pkg.sv
`timescale 1ns/1ps
package hdlc_tx_pkg;
    typedef enum logic [1:0] {
        TX_FLAG = 2'd0,
        TX_DATA = 2'd1,
        TX_CRC  = 2'd2
    } tx_state_e;

    localparam logic [7:0]  FLAG_OCTET = 8'h7E;
    localparam logic [15:0] POLY_16    = 16'h1021;
    localparam logic [31:0] POLY_32    = 32'h04C11DB7;
    localparam int          CRC_MAX_W  = 32;
    localparam int          STUFF_RUN  = 5;
    localparam logic [1:0]  MODE_WIDE  = 2'b10;
endpackage

// File: rtl/hdlc_tx_crc.sv
`timescale 1ns/1ps
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 adv,
    input  logic                 din,
    input  logic                 wide,
    output logic [CRC_MAX_W-1:0] crc
);
    logic [CRC_MAX_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init) begin
            crc_d = '1;
        end else if (adv) begin
            if (wide) begin
                crc_d = {crc_q[CRC_MAX_W-2:0], 1'b0}
                      ^ ((crc_q[CRC_MAX_W-1] ^ din) ? POLY_32 : '0);
            end else begin
                crc_d[15:0] = {crc_q[14:0], 1'b0}
                            ^ ((crc_q[15] ^ din) ? POLY_16 : 16'h0000);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/hdlc_tx_ctrl.sv
`timescale 1ns/1ps
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_min_flags,
    input  logic [1:0]           cfg_crc_mode,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_last,
    output logic                 in_ready,
    input  logic [CRC_MAX_W-1:0] crc_val,
    output logic                 crc_init,
    output logic                 crc_adv,
    output logic                 crc_din,
    output logic                 crc_wide,
    output logic                 tx_bit
);
    localparam int FC_W = CNT_W + 1;
    localparam logic [FC_W-1:0] FC_MAX = FC_W'((1 << CNT_W) + 1);
    localparam int IDX_W = $clog2(CRC_MAX_W);

    typedef struct packed {
        tx_state_e        st;
        logic [IDX_W-1:0] idx;
        logic [7:0]       sh;
        logic             last;
        logic [2:0]       ones;
        logic [FC_W-1:0]  fcnt;
        logic             locked;
        logic [CNT_W-1:0] need_n;
        logic             wide;
        logic             txb;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic [CNT_W-1:0] need_sel;
    logic [FC_W-1:0]  need_full;
    logic [FC_W-1:0]  fc_inc;
    logic             enough;
    logic             stuff;
    logic             line;
    logic [IDX_W-1:0] crc_top;
    logic [IDX_W-1:0] crc_pos;

    always_comb begin
        r_d      = r_q;
        in_ready = 1'b0;
        crc_init = 1'b0;
        crc_adv  = 1'b0;
        crc_din  = 1'b0;
        line     = 1'b0;

        need_sel  = r_q.locked ? r_q.need_n : cfg_min_flags;
        need_full = {1'b0, need_sel} + FC_W'(2);
        fc_inc    = (r_q.fcnt == FC_MAX) ? r_q.fcnt : r_q.fcnt + 1'b1;
        enough    = (fc_inc >= need_full);
        stuff     = (r_q.ones == 3'(STUFF_RUN));
        crc_top   = r_q.wide ? IDX_W'(CRC_MAX_W - 1) : IDX_W'(15);
        crc_pos   = crc_top - r_q.idx;

        if (stuff) begin
            line     = 1'b0;
            r_d.ones = 3'd0;
        end else begin
            unique case (r_q.st)
                TX_FLAG: begin
                    line     = FLAG_OCTET[r_q.idx[2:0]];
                    r_d.ones = 3'd0;
                    r_d.idx  = r_q.idx + 1'b1;
                    if (r_q.idx == IDX_W'(7)) begin
                        r_d.idx  = '0;
                        r_d.fcnt = fc_inc;
                        if (enough) begin
                            in_ready = 1'b1;
                            if (in_valid) begin
                                r_d.st     = TX_DATA;
                                r_d.sh     = in_data;
                                r_d.last   = in_last;
                                r_d.wide   = (cfg_crc_mode == MODE_WIDE);
                                r_d.locked = 1'b0;
                                crc_init   = 1'b1;
                            end
                        end
                    end
                end
                TX_DATA: begin
                    line     = r_q.sh[0];
                    crc_adv  = 1'b1;
                    crc_din  = line;
                    r_d.sh   = {1'b0, r_q.sh[7:1]};
                    r_d.ones = line ? r_q.ones + 1'b1 : 3'd0;
                    r_d.idx  = r_q.idx + 1'b1;
                    if (r_q.idx == IDX_W'(7)) begin
                        r_d.idx = '0;
                        if (!r_q.last) in_ready = 1'b1;
                        if (!r_q.last && in_valid) begin
                            r_d.sh   = in_data;
                            r_d.last = in_last;
                        end else begin
                            r_d.st = TX_CRC;
                        end
                    end
                end
                TX_CRC: begin
                    line     = ~crc_val[crc_pos];
                    r_d.ones = line ? r_q.ones + 1'b1 : 3'd0;
                    r_d.idx  = r_q.idx + 1'b1;
                    if (r_q.idx == crc_top) begin
                        r_d.st     = TX_FLAG;
                        r_d.idx    = '0;
                        r_d.fcnt   = '0;
                        r_d.locked = 1'b1;
                        r_d.need_n = cfg_min_flags;
                    end
                end
                default: begin
                    r_d.st  = TX_FLAG;
                    r_d.idx = '0;
                end
            endcase
        end
        r_d.txb = line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= TX_FLAG;
            r_q.idx    <= '0;
            r_q.sh     <= '0;
            r_q.last   <= 1'b0;
            r_q.ones   <= 3'd0;
            r_q.fcnt   <= FC_W'(1);
            r_q.locked <= 1'b0;
            r_q.need_n <= '0;
            r_q.wide   <= 1'b0;
            r_q.txb    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign crc_wide = r_q.wide;
    assign tx_bit   = r_q.txb;
endmodule

// File: rtl/hdlc_tx_framer.sv
`timescale 1ns/1ps
module hdlc_tx_framer
    import hdlc_tx_pkg::*;
#(
    parameter int MIN_FLAG_W = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MIN_FLAG_W-1:0] cfg_min_flags,
    input  logic [1:0]            cfg_crc_mode,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    input  logic                  in_last,
    output logic                  in_ready,
    output logic                  tx_bit
);
    logic                 crc_init;
    logic                 crc_adv;
    logic                 crc_din;
    logic                 crc_wide;
    logic [CRC_MAX_W-1:0] crc_val;

    hdlc_tx_ctrl #(
        .CNT_W (MIN_FLAG_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_min_flags (cfg_min_flags),
        .cfg_crc_mode  (cfg_crc_mode),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_last       (in_last),
        .in_ready      (in_ready),
        .crc_val       (crc_val),
        .crc_init      (crc_init),
        .crc_adv       (crc_adv),
        .crc_din       (crc_din),
        .crc_wide      (crc_wide),
        .tx_bit        (tx_bit)
    );

    hdlc_tx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .adv   (crc_adv),
        .din   (crc_din),
        .wide  (crc_wide),
        .crc   (crc_val)
    );
endmodule

// File: rtl/hdlc_tx_checker.sv
`timescale 1ns/1ps
module hdlc_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic tx_bit,
    input logic crc_init,
    input logic crc_adv
);
    localparam int RUN_W = 4;
    localparam int GAP_W = 8;

    logic [RUN_W-1:0] ones_run;
    logic [GAP_W-1:0] since_acc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_run  <= '0;
            since_acc <= '1;
        end else begin
            if (tx_bit) ones_run <= (ones_run == '1) ? ones_run : ones_run + 1'b1;
            else        ones_run <= '0;
            if (in_valid && in_ready)  since_acc <= GAP_W'(1);
            else if (since_acc != '1)  since_acc <= since_acc + 1'b1;
        end
    end

    p_max_six_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ones_run <= RUN_W'(6));

    p_accept_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (since_acc >= GAP_W'(8)));

    p_ready_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    p_init_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        crc_init |-> (in_valid && in_ready));

    p_init_not_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_init && crc_adv));
endmodule

bind hdlc_tx_framer hdlc_tx_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_bit   (tx_bit),
    .crc_init (crc_init),
    .crc_adv  (crc_adv)
);

// File: tb/hdlc_tx_framer_bench.sv
`timescale 1ns/1ps
module hdlc_tx_framer_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cfg_min_flags;
    logic [1:0] cfg_crc_mode;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_ready;
    logic       tx_bit;

    always #2.5 clk = ~clk;

    hdlc_tx_framer u_hdlc_tx_framer (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_min_flags (cfg_min_flags),
        .cfg_crc_mode  (cfg_crc_mode),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_last       (in_last),
        .in_ready      (in_ready),
        .tx_bit        (tx_bit)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [7:0] exp_data [0:63][0:15];
    int         exp_n    [0:63];
    bit         exp_wide [0:63];
    int         exp_gmin [0:63];
    bit         exp_gx   [0:63];
    int         wr = 0;
    int         rd = 0;
    logic [7:0] tmp [0:15];

    bit rbuf [0:511];
    int blen = 0;
    int ones = 0;
    int maxrun = 0;
    bit hunting = 1;
    int flags_since = 0;

    function automatic void chk(input bit ok, input string req, input string what,
                                input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] crc_ref(input int f);
        logic [31:0] c = '1;
        for (int i = 0; i < exp_n[f]; i++)
            for (int j = 0; j < 8; j++) begin
                logic b = exp_data[f][i][j];
                if (exp_wide[f]) c = {c[30:0], 1'b0} ^ ((c[31] ^ b) ? 32'h04C11DB7 : 32'h0);
                else c[15:0] = {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0);
            end
        return c;
    endfunction

    function automatic void check_frame();
        int n, w, mism;
        logic [31:0] c;
        logic e;
        if (rd >= wr) begin
            chk(0, "R1", "unexpected frame on line, bits", blen, 0);
            return;
        end
        n = exp_n[rd];
        w = exp_wide[rd] ? 32 : 16;
        c = crc_ref(rd);
        mism = -1;
        chk(blen == 8*n + w, "R11 R5", "frame body length", blen, 8*n + w);
        if (blen == 8*n + w) begin
            for (int k = 0; k < blen; k++) begin
                if (k < 8*n) e = exp_data[rd][k/8][k%8];
                else         e = ~c[w-1-(k-8*n)];
                if (mism < 0 && rbuf[k] != e) mism = k;
            end
            chk(mism < 0, "R2 R4", "first mismatching bit index", mism, -1);
        end
        if (exp_gx[rd]) chk(flags_since == exp_gmin[rd], "R6/R7/R8/R9", "flags before frame",
                            flags_since, exp_gmin[rd]);
        else            chk(flags_since >= exp_gmin[rd], "R6", "flags before frame (min)",
                            flags_since, exp_gmin[rd]);
        rd++;
    endfunction

    // serial receiver model: destuff, find flags, collect frames
    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_bit) begin
                ones++;
                if (ones > maxrun) maxrun = ones;
                rbuf[blen] = 1'b1;
                blen = (blen < 511) ? blen + 1 : 0;
            end else begin
                if (ones == 5) begin
                end else if (ones == 6) begin
                    blen = (blen >= 7) ? blen - 7 : 0;
                    if (hunting) begin
                        hunting = 0;
                        flags_since = 1;
                    end else if (blen > 0) begin
                        check_frame();
                        flags_since = 1;
                    end else begin
                        flags_since++;
                    end
                    blen = 0;
                end else begin
                    rbuf[blen] = 1'b0;
                    blen = (blen < 511) ? blen + 1 : 0;
                end
                ones = 0;
            end
        end
    end

    task automatic queue_frame(input int nb, input bit wide, input int gmin, input bit gx);
        for (int i = 0; i < nb; i++) exp_data[wr][i] = tmp[i];
        exp_n[wr] = nb;
        exp_wide[wr] = wide;
        exp_gmin[wr] = gmin;
        exp_gx[wr] = gx;
        wr++;
    endtask

    task automatic send_frame(input int nb, input bit flip_mode);
        for (int i = 0; i < nb; i++) begin
            in_data  = tmp[i];
            in_last  = (i == nb - 1);
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            if (flip_mode && i == 0) cfg_crc_mode = 2'b10;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic fill_random(input int nb);
        for (int i = 0; i < nb; i++) tmp[i] = 8'($urandom_range(0, 255));
    endtask

    task automatic wait_rx();
        int t = 0;
        while (rd != wr && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int f0, r0, lowcnt, nfr, nb, nmin;
        bit wd;
        void'($urandom(32'd2417));
        rst_n = 1'b0;
        cfg_min_flags = 4'd5;
        cfg_crc_mode = 2'b00;
        in_valid = 1'b0;
        in_data = 8'h00;
        in_last = 1'b0;
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b0, "R10", "ready in reset", int'(in_ready), 0);
        chk(tx_bit == 1'b0, "R1", "line bit in reset", int'(tx_bit), 0);
        rst_n = 1'b1;

        // R9: frame offered right after reset, N=5 -> 6 flags
        tmp[0] = 8'hA5; tmp[1] = 8'h3C; tmp[2] = 8'h01;
        queue_frame(3, 0, 6, 1);
        send_frame(3, 0);
        wait_rx();

        // R1: idle line carries only flags
        f0 = flags_since;
        r0 = rd;
        repeat (160) @(negedge clk);
        chk(flags_since - f0 >= 19, "R1", "idle flags in 160 cycles", flags_since - f0, 19);
        chk(rd == r0, "R1", "frames seen while idle", rd - r0, 0);

        // R7 and R3: N=0, back-to-back, ones-heavy data
        cfg_min_flags = 4'd0;
        tmp[0] = 8'hFF; tmp[1] = 8'hFF; tmp[2] = 8'h7E; tmp[3] = 8'h00;
        queue_frame(4, 0, 2, 0);
        send_frame(4, 0);
        fill_random(5);
        queue_frame(5, 0, 2, 1);
        send_frame(5, 0);
        tmp[0] = 8'hFF; tmp[1] = 8'hF8;
        queue_frame(2, 0, 2, 1);
        send_frame(2, 0);
        wait_rx();

        // R6: N=4, CRC-32, back-to-back
        cfg_min_flags = 4'd4;
        cfg_crc_mode = 2'b10;
        for (int k = 0; k < 3; k++) begin
            fill_random(6);
            queue_frame(6, 1, (k == 0) ? 2 : 6, k != 0);
            send_frame(6, 0);
        end
        wait_rx();

        // R5: mode flipped after first byte accepted must not change this frame
        cfg_crc_mode = 2'b00;
        cfg_min_flags = 4'd1;
        fill_random(4);
        queue_frame(4, 0, 2, 0);
        send_frame(4, 1);
        wait_rx();

        // R5: reserved code 2'b11 gives CRC-16
        cfg_crc_mode = 2'b11;
        fill_random(3);
        queue_frame(3, 0, 2, 0);
        send_frame(3, 0);
        wait_rx();

        // R10: ready low through last byte bits and CRC
        cfg_crc_mode = 2'b00;
        fill_random(2);
        queue_frame(2, 0, 2, 0);
        send_frame(2, 0);
        lowcnt = 0;
        for (int k = 0; k < 23; k++) begin
            if (!in_ready) lowcnt++;
            @(negedge clk);
        end
        chk(lowcnt == 23, "R10", "cycles ready low after final byte", lowcnt, 23);
        wait_rx();

        // R8: spacing change during a gap applies to the following gap
        cfg_min_flags = 4'd7;
        fill_random(3);
        queue_frame(3, 0, 2, 0);
        send_frame(3, 0);
        fill_random(4);
        queue_frame(4, 0, 9, 1);
        fork
            send_frame(4, 0);
            begin
                repeat (48) @(negedge clk);
                cfg_min_flags = 4'd0;
            end
        join
        fill_random(2);
        queue_frame(2, 0, 2, 1);
        send_frame(2, 0);
        wait_rx();

        // random bursts
        for (int b = 0; b < 6; b++) begin
            nmin = $urandom_range(0, 15);
            wd = ($urandom_range(0, 1) == 1);
            cfg_min_flags = 4'(nmin);
            cfg_crc_mode = wd ? 2'b10 : 2'b00;
            nfr = $urandom_range(1, 3);
            for (int k = 0; k < nfr; k++) begin
                nb = $urandom_range(1, 12);
                fill_random(nb);
                queue_frame(nb, wd, (k == 0) ? 2 : nmin + 2, k != 0);
                send_frame(nb, 0);
            end
            wait_rx();
        end

        wait_rx();
        chk(rd == wr, "R11", "frames received", rd, wr);
        chk(maxrun <= 6, "R3", "longest run of ones", maxrun, 6);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule